// File: doc/BRIEF.md
# Modulated alarm tone generator

This block produces the drive signal for an alarm speaker transistor from a 32768 Hz clock. A raw alarm input is synchronised and debounced. The block compares the debounced level with a build-time active polarity. While the alarm is active, the output carries a 2048 Hz square tone. That tone is switched by an 8 Hz modulation and then cut into on/off bursts. The burst pattern is either 0.5 s on / 0.5 s off, or 1 s on / 3 s off.

All timing comes from one phase counter. The counter is held at zero while the alarm is inactive and counts from zero once it becomes active, so every alarm starts with a burst on-phase and a fresh modulation cycle. The debounce samples the synchronised input at 128 Hz and accepts a new level only after four equal samples in a row. The idle output level is a parameter, so the same block can drive an npn stage (idle low) or a pnp stage (idle high).

Top module: `alarm_tone_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `alarm_out` sits at the idle level `IDLE_HIGH`.
- R2: The alarm becomes active only after the input has shown the new level at SAMPLES (default 4) consecutive sample ticks. The ticks are spaced 2^SAMPLE_LOG2 clocks apart. The delay from an input change to activation therefore lies between (SAMPLES-1) and SAMPLES tick periods, plus a few clocks for synchronisation.
- R3: An input pulse covering fewer than SAMPLES sample ticks is ignored, and `alarm_out` stays at the idle level.
- R4: The input counts as asserted when it equals `ACTIVE_HIGH` (1: a high input raises the alarm; 0: a low input raises it).
- R5: Whenever the tone is not sounding, `alarm_out` equals `IDLE_HIGH` (0 for an npn driver, 1 for a pnp driver). A sounding tone drives the complement of the idle level.
- R6: Let k be the number of clocks since activation. The tone component is `(k / 2^TONE_LOG2) mod 2`. It starts at the idle level and toggles every 2^TONE_LOG2 clocks (2048 Hz by default).
- R7: Within each modulation period of 2^MOD_LOG2 clocks (8 Hz by default), the tone may sound only in the first half. The second half is idle.
- R8: With `BURST_HALF`, the tone may sound only in the first 2^SLOT_LOG2 clocks (0.5 s) of every 2·2^SLOT_LOG2-clock window.
- R9: With `BURST_QUARTER`, the tone may sound only in the first 2·2^SLOT_LOG2 clocks (1 s) of every 8·2^SLOT_LOG2-clock window (4 s).
- R10: Each activation restarts tone, modulation and burst timing at k = 0, so the first burst is always an on-phase.
- R11: When the debounced alarm drops, `alarm_out` returns to idle in that same cycle and stays idle until the next activation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_in | input | 1 | Raw, asynchronous alarm input |
| alarm_out | output | 1 | Drive for the external speaker transistor |

## Verification
The assertions assume that `alarm_in` is a slow level whose only legitimate changes are separated by more than one debounce window. They also assume the phase counter never has to represent more than one 8-slot window, because it wraps seamlessly there. The stimulus respects both assumptions:
- It holds every level long enough for the debounced state to settle before the next change, except in the deliberate short-pulse cases.
- It builds the block with reduced divider exponents, so that several full burst windows fit in a short run while the ratios between tone, modulation and burst stay as at the defaults.

// File: rtl/alarm_tone_pkg.sv
package alarm_tone_pkg;

  // Burst pattern, expressed in slots of 2^SLOT_LOG2 clocks (0.5 s at defaults)
  typedef enum logic [0:0] {
    BURST_HALF    = 1'b0,   // one slot on, one slot off
    BURST_QUARTER = 1'b1    // two slots on, six slots off
  } burst_mode_e;

  localparam int unsigned SLOT_IDX_W = 3;  // eight slots per full window

  // Burst gate for a slot index inside the eight-slot window
  function automatic logic burst_gate(input logic [SLOT_IDX_W-1:0] slot,
                                      input burst_mode_e          mode);
    logic open;
    if (mode == BURST_HALF) open = ~slot[0];
    else                    open = (slot[2:1] == 2'b00);
    return open;
  endfunction

  // Modulation gate: open in the first half of each modulation period
  function automatic logic mod_gate(input logic period_msb);
    return ~period_msb;
  endfunction

  // Tone level from the bit that flips every tone half-period
  function automatic logic tone_level(input logic half_bit);
    return half_bit;
  endfunction

endpackage

// File: rtl/atg_sample_timer.sv
module atg_sample_timer #(
  parameter int unsigned SAMPLE_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (SAMPLE_LOG2 < 1) ? 1 : SAMPLE_LOG2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign tick = &cnt_q;

endmodule

// File: rtl/atg_debounce.sv
module atg_debounce #(
  parameter int unsigned SAMPLES     = 4,
  parameter bit          ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw,
  output logic active
);
  localparam int unsigned HW       = (SAMPLES < 2) ? 1 : SAMPLES - 1;
  localparam logic        IDLE_LVL = ~ACTIVE_HIGH;

  logic          sync1_q, sync2_q;
  logic [HW-1:0] hist_q;
  logic          level_q;
  logic          agree;

  // Two-stage synchroniser, reset to the inactive level
  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= IDLE_LVL;
      sync2_q <= IDLE_LVL;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
    end
  end

  // Sample history, one entry per tick
  generate
    if (HW == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (rst)       hist_q <= IDLE_LVL;
        else if (tick) hist_q <= sync2_q;
      end
    end else begin : g_histn
      always_ff @(posedge clk) begin
        if (rst)       hist_q <= {HW{IDLE_LVL}};
        else if (tick) hist_q <= {hist_q[HW-2:0], sync2_q};
      end
    end
  endgenerate

  // New sample plus stored history all equal
  assign agree = (hist_q == {HW{sync2_q}});

  always_ff @(posedge clk) begin
    if (rst)                level_q <= IDLE_LVL;
    else if (tick && agree) level_q <= sync2_q;
  end

  assign active = (level_q == ACTIVE_HIGH);

endmodule

// File: rtl/atg_phase_gen.sv
module atg_phase_gen
  import alarm_tone_pkg::*;
#(
  parameter int unsigned TONE_LOG2  = 3,
  parameter int unsigned MOD_LOG2   = 12,
  parameter int unsigned SLOT_LOG2  = 14,
  parameter burst_mode_e BURST_MODE = BURST_HALF,
  localparam int unsigned PW        = SLOT_LOG2 + SLOT_IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  output logic [PW-1:0] phase,
  output logic          tone_bit,
  output logic          mod_open,
  output logic          burst_on
);
  logic [PW-1:0] phase_q;

  // Held at zero while idle, so each activation starts at k = 0
  always_ff @(posedge clk) begin
    if (rst || !active) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  assign phase    = phase_q;
  assign tone_bit = tone_level(phase_q[TONE_LOG2]);
  assign mod_open = mod_gate(phase_q[MOD_LOG2-1]);
  assign burst_on = burst_gate(phase_q[PW-1 -: SLOT_IDX_W], BURST_MODE);

endmodule

// File: rtl/alarm_tone_gen.sv
module alarm_tone_gen
  import alarm_tone_pkg::*;
#(
  parameter int unsigned SAMPLE_LOG2 = 8,
  parameter int unsigned SAMPLES     = 4,
  parameter int unsigned TONE_LOG2   = 3,
  parameter int unsigned MOD_LOG2    = 12,
  parameter int unsigned SLOT_LOG2   = 14,
  parameter burst_mode_e BURST_MODE  = BURST_HALF,
  parameter bit          ACTIVE_HIGH = 1'b1,
  parameter bit          IDLE_HIGH   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic alarm_in,
  output logic alarm_out
);
  localparam int unsigned PHASE_W = SLOT_LOG2 + SLOT_IDX_W;

  // Named internal events
  logic               sample_tick;
  logic               alarm_active;
  logic [PHASE_W-1:0] phase;
  logic               tone_bit;
  logic               mod_open;
  logic               burst_on;
  logic               drive;

  atg_sample_timer #(.SAMPLE_LOG2(SAMPLE_LOG2)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (sample_tick)
  );

  atg_debounce #(.SAMPLES(SAMPLES), .ACTIVE_HIGH(ACTIVE_HIGH)) u_deb (
    .clk    (clk),
    .rst    (rst),
    .tick   (sample_tick),
    .raw    (alarm_in),
    .active (alarm_active)
  );

  atg_phase_gen #(
    .TONE_LOG2  (TONE_LOG2),
    .MOD_LOG2   (MOD_LOG2),
    .SLOT_LOG2  (SLOT_LOG2),
    .BURST_MODE (BURST_MODE)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .active   (alarm_active),
    .phase    (phase),
    .tone_bit (tone_bit),
    .mod_open (mod_open),
    .burst_on (burst_on)
  );

  assign drive     = alarm_active & burst_on & mod_open & tone_bit;
  assign alarm_out = IDLE_HIGH ^ drive;

endmodule

// File: rtl/alarm_tone_gen_chk.sv
module alarm_tone_gen_chk #(
  parameter int unsigned PW        = 17,
  parameter int unsigned TONE_LOG2 = 3,
  parameter bit          IDLE_HIGH = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic          sample_tick,
  input logic          alarm_active,
  input logic [PW-1:0] phase,
  input logic          mod_open,
  input logic          burst_on,
  input logic          alarm_out
);
  // R5, R11: no activity on the output while the alarm is off
  a_r11_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !alarm_active |-> alarm_out == IDLE_HIGH);

  // R2: the debounced state moves only on a sample tick
  a_r2_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(alarm_active) |-> $past(sample_tick));

  // R10: timing restarts from zero at every activation
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_active) |-> phase == '0);

  // R7: second half of a modulation period is silent
  a_r7_mod_silent: assert property (@(posedge clk) disable iff (rst)
    !mod_open |-> alarm_out == IDLE_HIGH);

  // R8, R9: off-phase of a burst is silent
  a_r8_burst_silent: assert property (@(posedge clk) disable iff (rst)
    !burst_on |-> alarm_out == IDLE_HIGH);

  // R6: while active the output changes only on tone half-period boundaries
  a_r6_tone_edge: assert property (@(posedge clk) disable iff (rst)
    (alarm_active && $past(alarm_active) && !$stable(alarm_out))
      |-> phase[TONE_LOG2-1:0] == '0);

  // R1: output idle in reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> alarm_out == IDLE_HIGH);

endmodule

bind alarm_tone_gen alarm_tone_gen_chk #(
  .PW        (PHASE_W),
  .TONE_LOG2 (TONE_LOG2),
  .IDLE_HIGH (IDLE_HIGH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_tick  (sample_tick),
  .alarm_active (alarm_active),
  .phase        (phase),
  .mod_open     (mod_open),
  .burst_on     (burst_on),
  .alarm_out    (alarm_out)
);

// File: tb/alarm_tone_gen_tb.sv
`timescale 1ns/1ps
module alarm_tone_gen_tb;
  import alarm_tone_pkg::*;

  localparam int S_LOG2 = 3;
  localparam int T_LOG2 = 1;
  localparam int M_LOG2 = 4;
  localparam int L_LOG2 = 5;
  localparam int S      = 8;    // sample spacing
  localparam int THALF  = 2;    // tone half period
  localparam int MPER   = 16;   // modulation period
  localparam int SLOT   = 32;   // burst slot

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_a = 1'b0;   // dut A: active high, npn idle low, half bursts
  logic raw_b = 1'b1;   // dut B: active low, pnp idle high, quarter bursts
  logic out_a, out_b;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   act_edge [2];
  bit   done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alarm_tone_gen #(
    .SAMPLE_LOG2(S_LOG2), .SAMPLES(4), .TONE_LOG2(T_LOG2), .MOD_LOG2(M_LOG2),
    .SLOT_LOG2(L_LOG2), .BURST_MODE(BURST_HALF), .ACTIVE_HIGH(1'b1), .IDLE_HIGH(1'b0)
  ) u_dut (.clk(clk), .rst(rst), .alarm_in(raw_a), .alarm_out(out_a));

  alarm_tone_gen #(
    .SAMPLE_LOG2(S_LOG2), .SAMPLES(4), .TONE_LOG2(T_LOG2), .MOD_LOG2(M_LOG2),
    .SLOT_LOG2(L_LOG2), .BURST_MODE(BURST_QUARTER), .ACTIVE_HIGH(1'b0), .IDLE_HIGH(1'b1)
  ) u_dut_b (.clk(clk), .rst(rst), .alarm_in(raw_b), .alarm_out(out_b));

  function automatic logic idle_of(input bit b);
    return b ? 1'b1 : 1'b0;
  endfunction

  function automatic logic out_of(input bit b);
    return b ? out_b : out_a;
  endfunction

  // Expected output k clocks after activation, written from the requirements
  function automatic logic expect_out(input bit b, input int k);
    bit tone, modo, burst;
    tone  = ((k / THALF) % 2) == 1;
    modo  = (k % MPER) < (MPER / 2);
    burst = b ? ((k % (8 * SLOT)) < (2 * SLOT)) : ((k % (2 * SLOT)) < SLOT);
    return idle_of(b) ^ (tone & modo & burst);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cyc, act, exp);
    end
  endtask

  task automatic set_alarm(input bit b, input bit on);
    if (b) raw_b = on ? 1'b0 : 1'b1;   // R4: dut B asserts on a low input
    else   raw_a = on ? 1'b1 : 1'b0;   // R4: dut A asserts on a high input
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 dut A idle low in reset", out_a, 1'b0);
    check("R1 R5 dut B idle high in reset", out_b, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dut A idle after reset", out_a, 1'b0);
    check("R1 dut B idle after reset", out_b, 1'b1);
  endtask

  task automatic t_glitch(input bit b);
    set_alarm(b, 1'b1);
    for (int i = 0; i < 2 * S; i++) begin
      @(negedge clk);
      check("R3 short pulse ignored", out_of(b), idle_of(b));
    end
    set_alarm(b, 1'b0);
    for (int i = 0; i < 6 * S; i++) begin
      @(negedge clk);
      check("R3 stays idle after short pulse", out_of(b), idle_of(b));
    end
  endtask

  task automatic t_activate(input bit b, input int span);
    int c, e, a, k;
    bit found;
    c = cyc;
    found = 1'b0;
    e = 0;
    set_alarm(b, 1'b1);
    for (int i = 0; i < 6 * S + 20 && !found; i++) begin
      @(negedge clk);
      if (out_of(b) !== idle_of(b)) begin
        found = 1'b1;
        e = cyc;
      end
    end
    checks++;
    if (!found) begin
      fails++;
      $display("FAIL R2 R4 no tone after activation: actual=idle expected=tone");
    end else begin
      a = e - THALF;   // R6: first non-idle level one tone half period in
      act_edge[b] = a;
      checks++;
      if ((a - c) < 3 * S + 1 || (a - c) > 4 * S + 3) begin
        fails++;
        $display("FAIL R2 debounce latency: actual=%0d expected=%0d..%0d",
                 a - c, 3 * S + 1, 4 * S + 3);
      end
      for (int i = 0; i < span; i++) begin
        @(negedge clk);
        k = cyc - a;
        check(b ? "R6 R7 R9 R10 pattern B" : "R6 R7 R8 R10 pattern A",
              out_of(b), expect_out(b, k));
      end
    end
  endtask

  task automatic t_release(input bit b);
    int c, d, k;
    c = cyc;
    set_alarm(b, 1'b0);
    for (int i = 0; i < 4 * S + 100; i++) begin
      @(negedge clk);
      d = cyc - c;
      k = cyc - act_edge[b];
      if (d <= 3 * S + 2)
        check("R11 tone continues before release accepted", out_of(b), expect_out(b, k));
      else if (d >= 4 * S + 3)
        check("R11 idle after release", out_of(b), idle_of(b));
      else if (out_of(b) !== idle_of(b))
        check("R11 tone in release window", out_of(b), expect_out(b, k));
    end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL R1-watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_glitch(1'b0);
    t_glitch(1'b1);
    t_activate(1'b0, 4 * SLOT);
    t_release(1'b0);
    t_activate(1'b0, 2 * SLOT + 10);   // R10: second activation restarts at k = 0
    t_release(1'b0);
    t_activate(1'b1, 16 * SLOT + 20);
    t_release(1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule